// File: doc/BRIEF.md
# Programmable-Rate Full-Duplex Serial Master

This block drives a four-wire synchronous serial link as the bus master. Each exchange shifts one word out on the data-out line while shifting one word in from the data-in line. The word length is from 1 to 16 bits and the bit rate is programmable. The serial clock toggles only while a word is moving. An active-low select line stays low for the whole word and serves as the frame sync that the attached converter or peripheral needs.

Software or a sequencer sets a 7-bit rate divisor and a 4-bit length code. It then places a word on the transmit port and pulses the start strobe. The divisor and length are latched at the start, so changes during a frame have no effect. When the word has been exchanged, the received bits appear right-justified in the receive register and a sticky done flag rises. A read strobe on the receive register clears the flag. The rate follows an uneven rule: a divisor of 0, 1 or 2 behaves like a divisor of 3, and larger values divide the system clock by the divisor plus one. This gives 125 usable rates.

Top module: `spi_master_engine`

## Requirements
- R1: For a latched divisor D from 3 to 127, one serial bit lasts P = D+1 system cycles. In each bit the clock is low for P - floor(P/2) cycles and then high for floor(P/2) cycles.
- R2: A divisor of 0, 1 or 2 gives P = 4, with the clock low for 2 cycles and high for 2 cycles.
- R3: A length code C (0 to 15) selects C+1 bits. The select line goes low on the first clock edge after an accepted start and stays low for exactly (C+1)*P cycles, during which exactly C+1 rising serial-clock edges occur.
- R4: Data out carries bits C down to 0 of the transmit word, most significant first. It changes only together with a falling serial-clock edge or at the frame start, never while the clock is high, and the slave samples it on the rising edge.
- R5: Data in is sampled on every rising serial-clock edge. At the edge that ends the frame, the receive register takes the C+1 captured bits right-justified, with the first captured bit highest and all upper bits zero.
- R6: While the select line is high the serial clock is low and data out is low.
- R7: The done flag rises on the same edge where the select line returns high, and stays set until it is cleared by a read.
- R8: A read strobe while the flag is set and no frame is ending clears the flag on the next edge.
- R9: A start strobe while a frame is running is ignored. It does not change the frame length, the transmitted bits or the received result.
- R10: After reset the select line is high, the serial clock and data out are low, the done flag is clear and the receive register is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System (peripheral) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_baud | input | 7 | Rate divisor, latched at start |
| cfg_len | input | 4 | Length code, bits = code + 1, latched at start |
| tx_data | input | 16 | Word to transmit, low C+1 bits used |
| start | input | 1 | Single-cycle start strobe |
| rx_rd | input | 1 | Read strobe for the receive register, clears done |
| rx_data | output | 16 | Right-justified received word |
| done_flag | output | 1 | Sticky exchange-complete flag |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| ste_n | output | 1 | Active-low slave enable / frame sync |
| miso | input | 1 | Serial data in |

## Verification
The select line falls one edge after the start is accepted. The first clock rise comes P - floor(P/2) cycles later, and the frame ends (P)*(C+1) cycles after it began. On that same edge the receive register and done flag update, and a read clears the flag one edge after the strobe. The bench drives inputs on falling system-clock edges and samples on every falling edge while the frame runs. It measures the low and high run lengths, the frame length and the rise count in whole cycles, and compares them with the period and phase values computed from the divisor. A slave model presents data-in bits at the frame start and after each falling serial edge, so every bit stays stable for at least two cycles before the rise that samples it.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
   typedef enum logic {
      ENG_IDLE  = 1'b0,
      ENG_SHIFT = 1'b1
   } eng_state_e;

   localparam int unsigned CLAMP_LIMIT  = 3;
   localparam int unsigned CLAMP_PERIOD = 4;
endpackage

// File: rtl/spi_eng_rate.sv
module spi_eng_rate #(
   parameter int unsigned DIV_W = 7,
   parameter int unsigned CNT_W = DIV_W + 1
) (
   input  logic [DIV_W-1:0] div_val,
   output logic [CNT_W-1:0] hi_len,
   output logic [CNT_W-1:0] lo_len
);
   import spi_eng_pkg::*;

   logic [CNT_W-1:0] period;

   if (CNT_W <= DIV_W) begin : g_bad_cnt
      $error("spi_eng_rate: CNT_W must exceed DIV_W");
   end

   always_comb begin
      if (div_val < DIV_W'(CLAMP_LIMIT))
         period = CNT_W'(CLAMP_PERIOD);
      else
         period = CNT_W'(div_val) + CNT_W'(1);
      hi_len = period >> 1;
      lo_len = period - hi_len;
   end
endmodule

// File: rtl/spi_eng_shift.sv
module spi_eng_shift #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned LEN_W  = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              shift_out,
   input  logic              sample,
   input  logic [LEN_W-1:0]  len_code,
   input  logic [DATA_W-1:0] tx_word,
   input  logic              miso,
   output logic              mosi_bit,
   output logic [DATA_W-1:0] rx_word
);
   localparam logic [LEN_W-1:0] TOP_IDX = LEN_W'(DATA_W - 1);

   logic [DATA_W-1:0] tx_sh;
   logic [DATA_W-1:0] rx_sh;
   logic [LEN_W-1:0]  align;

   assign align = TOP_IDX - len_code;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sh <= '0;
         rx_sh <= '0;
      end else if (load) begin
         tx_sh <= tx_word << align;
         rx_sh <= '0;
      end else begin
         if (shift_out)
            tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
         if (sample)
            rx_sh <= {rx_sh[DATA_W-2:0], miso};
      end
   end

   assign mosi_bit = tx_sh[DATA_W-1];
   assign rx_word  = rx_sh;
endmodule

// File: rtl/spi_master_engine.sv
module spi_master_engine #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned DIV_W  = 7,
   parameter int unsigned LEN_W  = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DIV_W-1:0]  cfg_baud,
   input  logic [LEN_W-1:0]  cfg_len,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              start,
   input  logic              rx_rd,
   output logic [DATA_W-1:0] rx_data,
   output logic              done_flag,
   output logic              sclk,
   output logic              mosi,
   output logic              ste_n,
   input  logic              miso
);
   import spi_eng_pkg::*;

   localparam int unsigned CNT_W = DIV_W + 1;

   if ((1 << LEN_W) != DATA_W) begin : g_bad_len
      $error("spi_master_engine: DATA_W must be 2**LEN_W");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("spi_master_engine: DATA_W must be at least 2");
   end

   eng_state_e        state;
   logic              sclk_q;
   logic [CNT_W-1:0]  ph_cnt;
   logic [LEN_W-1:0]  bits_left;
   logic [DIV_W-1:0]  div_q;
   logic [DATA_W-1:0] rx_q;
   logic              done_q;

   logic [CNT_W-1:0]  hi_len;
   logic [CNT_W-1:0]  lo_len;
   logic              accept, lo_end, hi_end;
   logic              do_sample, do_shift, finish;
   logic              mosi_bit;
   logic [DATA_W-1:0] rx_word;

   spi_eng_rate #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_rate (
      .div_val (div_q),
      .hi_len  (hi_len),
      .lo_len  (lo_len)
   );

   assign accept    = (state == ENG_IDLE) && start;
   assign lo_end    = (state == ENG_SHIFT) && !sclk_q && (ph_cnt == lo_len - CNT_W'(1));
   assign hi_end    = (state == ENG_SHIFT) &&  sclk_q && (ph_cnt == hi_len - CNT_W'(1));
   assign do_sample = lo_end;
   assign do_shift  = hi_end && (bits_left != '0);
   assign finish    = hi_end && (bits_left == '0);

   spi_eng_shift #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept),
      .shift_out (do_shift),
      .sample    (do_sample),
      .len_code  (cfg_len),
      .tx_word   (tx_data),
      .miso      (miso),
      .mosi_bit  (mosi_bit),
      .rx_word   (rx_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ENG_IDLE;
         sclk_q    <= 1'b0;
         ph_cnt    <= '0;
         bits_left <= '0;
         div_q     <= '0;
      end else begin
         case (state)
            ENG_IDLE: begin
               if (start) begin
                  state     <= ENG_SHIFT;
                  div_q     <= cfg_baud;
                  bits_left <= cfg_len;
                  ph_cnt    <= '0;
                  sclk_q    <= 1'b0;
               end
            end
            ENG_SHIFT: begin
               if (lo_end || hi_end) begin
                  ph_cnt <= '0;
                  sclk_q <= lo_end;
               end else begin
                  ph_cnt <= ph_cnt + CNT_W'(1);
               end
               if (do_shift)
                  bits_left <= bits_left - LEN_W'(1);
               if (finish)
                  state <= ENG_IDLE;
            end
            default: state <= ENG_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_q   <= '0;
         done_q <= 1'b0;
      end else begin
         if (finish)
            rx_q <= rx_word;
         if (finish)
            done_q <= 1'b1;
         else if (rx_rd)
            done_q <= 1'b0;
      end
   end

   assign rx_data   = rx_q;
   assign done_flag = done_q;
   assign sclk      = sclk_q;
   assign ste_n     = (state == ENG_IDLE);
   assign mosi      = (state == ENG_SHIFT) ? mosi_bit : 1'b0;
endmodule

// File: rtl/spi_master_engine_chk.sv
module spi_master_engine_chk #(
   parameter int unsigned DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              rx_rd,
   input logic [DATA_W-1:0] rx_data,
   input logic              done_flag,
   input logic              sclk,
   input logic              mosi,
   input logic              ste_n
);
   // R6
   idle_clock_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ste_n |-> (!sclk && !mosi));

   // R4
   mosi_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk && $past(sclk)) |-> $stable(mosi));

   // R7
   done_at_frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_flag) |-> $rose(ste_n));

   // R8
   read_clears_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_rd && ste_n) |=> !done_flag);

   // R9
   rx_hold_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ste_n && start) |=> ($stable(rx_data) || $rose(ste_n)));

   // R5
   rx_update_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ste_n) |=> ($stable(rx_data) || $rose(ste_n)));
endmodule

bind spi_master_engine spi_master_engine_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .rx_rd     (rx_rd),
   .rx_data   (rx_data),
   .done_flag (done_flag),
   .sclk      (sclk),
   .mosi      (mosi),
   .ste_n     (ste_n)
);

// File: tb/tb_spi_master_engine.sv
`timescale 1ns/1ps
module tb_spi_master_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [6:0]  cfg_baud = '0;
   logic [3:0]  cfg_len = '0;
   logic [15:0] tx_data = '0;
   logic        start = 1'b0;
   logic        rx_rd = 1'b0;
   logic [15:0] rx_data;
   logic        done_flag;
   logic        sclk;
   logic        mosi;
   logic        ste_n;
   logic        miso = 1'b0;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   spi_master_engine dut (
      .clk(clk), .rst_n(rst_n), .cfg_baud(cfg_baud), .cfg_len(cfg_len),
      .tx_data(tx_data), .start(start), .rx_rd(rx_rd), .rx_data(rx_data),
      .done_flag(done_flag), .sclk(sclk), .mosi(mosi), .ste_n(ste_n),
      .miso(miso)
   );

   function automatic int exp_period(input int d);
      return (d < 3) ? 4 : d + 1;
   endfunction

   function automatic int exp_hi(input int d);
      return exp_period(d) / 2;
   endfunction

   function automatic int exp_mask(input int nb);
      return (32'd1 << nb) - 1;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   task automatic xfer(input int d, input int c, input int txw, input int slvw, input bit hit_start);
      int nb, per, hi, frame, rises, lo_run, hi_run, cap, sidx, viol, guard;
      bit prev_s, prev_m, seen_rise, seen_fall;
      nb = c + 1; per = exp_period(d); hi = exp_hi(d);
      frame = 0; rises = 0; lo_run = 0; hi_run = 0; cap = 0; sidx = 0; viol = 0;
      prev_s = 0; prev_m = 0; seen_rise = 0; seen_fall = 0; guard = 0;
      @(negedge clk);
      cfg_baud = 7'(d); cfg_len = 4'(c); tx_data = 16'(txw); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!ste_n && guard < 5000) begin
         guard++;
         frame++;
         if (frame == 1) begin
            sidx = nb - 1;
            miso = slvw[sidx];
         end
         if (hit_start) begin
            if (frame == 3) begin start = 1'b1; tx_data = ~16'(txw); cfg_len = 4'(15 - c); end
            if (frame == 4) start = 1'b0;
         end
         if (sclk && !prev_s) begin
            rises++;
            cap = (cap << 1) | int'(mosi);
            seen_rise = 1;
         end
         if (!sclk && prev_s) begin
            seen_fall = 1;
            if (sidx > 0) begin sidx--; miso = slvw[sidx]; end
         end
         if (sclk && prev_s && (mosi != prev_m)) viol++;
         if (!seen_rise && !sclk) lo_run++;
         if (sclk && !seen_fall) hi_run++;
         prev_s = sclk; prev_m = mosi;
         @(negedge clk);
      end
      miso = 1'b0;
      // R3: frame length and rise count
      chk(frame == nb * per, "R3 frame cycles", frame, nb * per);
      chk(rises == nb, "R3 rising edges", rises, nb);
      // R1 / R2: low and high phase lengths
      if (d < 3) begin
         chk(lo_run == 2 && hi_run == 2, "R2 clamped phases", lo_run * 256 + hi_run, 2 * 256 + 2);
      end else begin
         chk(lo_run == per - hi && hi_run == hi, "R1 phases", lo_run * 256 + hi_run, (per - hi) * 256 + hi);
      end
      // R4: MSB-first data out, stable while high
      chk(cap == (txw & exp_mask(nb)), "R4 mosi bits", cap, txw & exp_mask(nb));
      chk(viol == 0, "R4 mosi stable high", viol, 0);
      // R5: right-justified receive
      chk(int'(rx_data) == (slvw & exp_mask(nb)), "R5 rx_data", int'(rx_data), slvw & exp_mask(nb));
      // R7: done on frame end
      chk(done_flag == 1'b1, "R7 done set", int'(done_flag), 1);
      // R6: idle clock low
      chk(sclk == 1'b0 && mosi == 1'b0, "R6 idle lines", int'({sclk, mosi}), 0);
      repeat (3) @(negedge clk);
      chk(done_flag == 1'b1, "R7 done sticky", int'(done_flag), 1);
      rx_rd = 1'b1;
      @(negedge clk);
      rx_rd = 1'b0;
      // R8: read clears flag
      chk(done_flag == 1'b0, "R8 done cleared", int'(done_flag), 0);
      chk(int'(rx_data) == (slvw & exp_mask(nb)), "R5 rx held after read", int'(rx_data), slvw & exp_mask(nb));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R10: reset state
      chk(ste_n == 1'b1 && sclk == 1'b0 && mosi == 1'b0, "R10 reset lines",
          int'({ste_n, sclk, mosi}), 4);
      chk(done_flag == 1'b0 && rx_data == 16'h0, "R10 reset regs", int'({done_flag, rx_data}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      // R2: clamped divisors
      xfer(0, 7, 16'hA5, 16'h3C, 0);
      xfer(1, 15, 16'hBEEF, 16'h1234, 0);
      xfer(2, 3, 16'h9, 16'h6, 0);
      // R1: smallest unclamped, odd and even periods, largest divisor
      xfer(3, 11, 16'h0F0F, 16'hFACE, 0);
      xfer(4, 5, 16'h2A, 16'h15, 0);
      xfer(127, 15, 16'hC3A5, 16'h5A3C, 0);
      // R3: single-bit word
      xfer(5, 0, 16'h1, 16'h1, 0);
      xfer(6, 0, 16'hFFFE, 16'hFFFF, 0);
      // R9: start during frame ignored
      xfer(8, 9, 16'h2B7, 16'h1C9, 1);
      for (int i = 0; i < 25; i++) begin
         xfer(int'($urandom % 40), int'($urandom % 16), int'($urandom & 16'hFFFF),
              int'($urandom & 16'hFFFF), bit'($urandom % 4 == 0));
      end
      report();
   end
endmodule